// File: doc/BRIEF.md
# Two-Window Shared GPIO Controller

This block controls up to 32 general-purpose pins that are shared by two bus masters. A privileged master reaches a full register set; a restricted master reaches a smaller mirror set. A per-pin owner mask decides which pins the restricted master may write. Both sets act on one shared copy of each pin setting, so a pin changes hands by flipping its owner bit and no data is copied.

Each pin can drive a value or float as an input. Inputs pass through a two-flop synchroniser. A level-held interrupt flag per pin is set while the synchronised input equals the pin's programmed trigger level. Each view has its own interrupt output: the privileged output covers the pins it keeps, and the restricted output covers the pins it owns.

Both bus ports decode the same 64-byte map of 32-bit words. Data bit n of every register belongs to pin n. Reads are combinational, and writes take effect at the next clock edge.

Top module: `gpio_dual_view`

## Requirements
- R1: The word index is address bits [5:2]. Indices 0..6 form the restricted window: drive value, direction, input, trigger level, flags, mask and mirror. Indices 7..15 form the privileged window: enable, drive value, direction, input, trigger level, flags, mask, mirror and owner. The restricted port reads 0 at indices 7..15 and ignores writes there. The privileged port may use both windows.
- R2: A pin with direction bit 1 and enable bit 1 drives its stored value, so `pin_oe`=1 and `pin_out` equals the stored bit. In every other case `pin_oe`=0 and `pin_out`=0.
- R3: While a pin's enable bit is 0, that pin never drives and its flag is never set. A flag that is already set is kept.
- R4: `pin_in` passes through two flops. A change becomes visible in the input register after the second rising edge.
- R5: A pin's flag becomes 1 at the edge after the synchronised input equals its trigger-level bit. Trigger level 1 means high and 0 means low.
- R6: Writing 1 to a flag bit clears it only when the synchronised input differs from the trigger level. Otherwise the flag stays 1.
- R7: In the restricted window, bits whose owner bit is 0 read as 0 and ignore writes.
- R8: In the privileged window, reads return all bits. Writes to drive value, direction, trigger level, flags and mask leave bits whose owner bit is 1 unchanged. Enable and owner are written in full.
- R9: `irq_priv` is 1 when any pin has mask=1, flag=1 and owner=0. `irq_rest` is 1 when any pin has mask=1, flag=1 and owner=1.
- R10: Setting an owner bit makes that pin's existing settings, including its mask, visible through the restricted window at once.
- R11: The mirror register loads the synchronised input at the third rising edge after reset release and holds it from then on.
- R12: After reset, drive value, direction, mask, flags and owner are 0. Trigger level is all ones and enable is 0x00FFFFFF.
- R13: When both ports write the same bit of a register in one cycle, the privileged port's value is stored.
- R14: Writes to the input and mirror registers have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| p_sel | input | 1 | Privileged port access strobe |
| p_wr | input | 1 | Privileged port write (1) or read (0) |
| p_addr | input | 6 | Privileged port byte address |
| p_wdata | input | 32 | Privileged port write data |
| p_rdata | output | 32 | Privileged port read data, 0 when idle |
| r_sel | input | 1 | Restricted port access strobe |
| r_wr | input | 1 | Restricted port write (1) or read (0) |
| r_addr | input | 6 | Restricted port byte address |
| r_wdata | input | 32 | Restricted port write data |
| r_rdata | output | 32 | Restricted port read data, 0 when idle |
| pin_in | input | 32 | Asynchronous pin input levels |
| pin_out | output | 32 | Pin drive values |
| pin_oe | output | 32 | Pin output enables |
| irq_priv | output | 1 | Privileged-view interrupt |
| irq_rest | output | 1 | Restricted-view interrupt |

## Verification
Flags are exercised with high-level and low-level triggers, with a disabled pin held at its trigger level, and with clear attempts made both while the pin still matches and after it has left the trigger level. This separates a latched flag from a plain level follower. Owner masks that leave the two views disjoint, and a cycle in which both ports write the same drive bits, separate write gating from write priority. Moving a masked, flagged pin between owners shows that the interrupt follows the owner bit through shared storage.

// File: rtl/gpio_dual_view.sv
`timescale 1ns/1ps
module gpio_dual_view #(
  parameter int NPINS = 32,
  parameter int DATA_W = 32,
  parameter int ADDR_W = 6,
  parameter logic [NPINS-1:0] EN_RESET = NPINS'(32'h00FF_FFFF)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              p_sel,
  input  logic              p_wr,
  input  logic [ADDR_W-1:0] p_addr,
  input  logic [DATA_W-1:0] p_wdata,
  output logic [DATA_W-1:0] p_rdata,
  input  logic              r_sel,
  input  logic              r_wr,
  input  logic [ADDR_W-1:0] r_addr,
  input  logic [DATA_W-1:0] r_wdata,
  output logic [DATA_W-1:0] r_rdata,
  input  logic [NPINS-1:0]  pin_in,
  output logic [NPINS-1:0]  pin_out,
  output logic [NPINS-1:0]  pin_oe,
  output logic              irq_priv,
  output logic              irq_rest
);
  localparam int IW = 4;
  localparam int NWORDS = 1 << IW;
  localparam logic [IW-1:0] RV_OUT = 4'd0, RV_DIR = 4'd1, RV_IN = 4'd2, RV_LVL = 4'd3,
                            RV_FLG = 4'd4, RV_MSK = 4'd5, RV_MIR = 4'd6;
  localparam logic [IW-1:0] PV_EN = 4'd7, PV_OUT = 4'd8, PV_DIR = 4'd9, PV_IN = 4'd10,
                            PV_LVL = 4'd11, PV_FLG = 4'd12, PV_MSK = 4'd13, PV_MIR = 4'd14,
                            PV_OWN = 4'd15;

  logic [NPINS-1:0] out_q, dir_q, lvl_q, msk_q, flg_q, en_q, own_q, mir_q;
  logic [NPINS-1:0] sync1_q, sync_q;
  logic [1:0]       init_cnt;
  logic             init_done;

  wire [IW-1:0]    p_idx = p_addr[IW+1:2];
  wire [IW-1:0]    r_idx = r_addr[IW+1:2];
  wire             p_we = p_sel & p_wr;
  wire             r_we = r_sel & r_wr & (r_idx <= RV_MIR);
  wire [NPINS-1:0] pd = p_wdata[NPINS-1:0];
  wire [NPINS-1:0] rd = r_wdata[NPINS-1:0];

  function automatic logic [NPINS-1:0] pmask(input logic [IW-1:0] ri, input logic [IW-1:0] pi,
                                             input logic [IW-1:0] idx, input logic we,
                                             input logic [NPINS-1:0] own);
    return ({NPINS{we && idx == pi}} & ~own) | ({NPINS{we && idx == ri}} & own);
  endfunction

  function automatic logic [NPINS-1:0] merge(input logic [NPINS-1:0] cur, input logic [NPINS-1:0] pm,
                                             input logic [NPINS-1:0] rm, input logic [NPINS-1:0] pv,
                                             input logic [NPINS-1:0] rv);
    logic [NPINS-1:0] rlo;
    rlo = rm & ~pm;
    return (cur & ~(pm | rlo)) | (pv & pm) | (rv & rlo);
  endfunction

  wire [NPINS-1:0] pm_out = pmask(RV_OUT, PV_OUT, p_idx, p_we, own_q);
  wire [NPINS-1:0] pm_dir = pmask(RV_DIR, PV_DIR, p_idx, p_we, own_q);
  wire [NPINS-1:0] pm_lvl = pmask(RV_LVL, PV_LVL, p_idx, p_we, own_q);
  wire [NPINS-1:0] pm_flg = pmask(RV_FLG, PV_FLG, p_idx, p_we, own_q);
  wire [NPINS-1:0] pm_msk = pmask(RV_MSK, PV_MSK, p_idx, p_we, own_q);
  wire [NPINS-1:0] rm_out = {NPINS{r_we && r_idx == RV_OUT}} & own_q;
  wire [NPINS-1:0] rm_dir = {NPINS{r_we && r_idx == RV_DIR}} & own_q;
  wire [NPINS-1:0] rm_lvl = {NPINS{r_we && r_idx == RV_LVL}} & own_q;
  wire [NPINS-1:0] rm_flg = {NPINS{r_we && r_idx == RV_FLG}} & own_q;
  wire [NPINS-1:0] rm_msk = {NPINS{r_we && r_idx == RV_MSK}} & own_q;

  wire [NPINS-1:0] match = ~(sync_q ^ lvl_q);
  wire [NPINS-1:0] clr   = (pm_flg & pd) | (rm_flg & rd);

  assign init_done = (init_cnt == 2'd3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q    <= '0;
      dir_q    <= '0;
      lvl_q    <= '1;
      msk_q    <= '0;
      flg_q    <= '0;
      en_q     <= EN_RESET;
      own_q    <= '0;
      mir_q    <= '0;
      sync1_q  <= '0;
      sync_q   <= '0;
      init_cnt <= '0;
    end else begin
      out_q   <= merge(out_q, pm_out, rm_out, pd, rd);
      dir_q   <= merge(dir_q, pm_dir, rm_dir, pd, rd);
      lvl_q   <= merge(lvl_q, pm_lvl, rm_lvl, pd, rd);
      msk_q   <= merge(msk_q, pm_msk, rm_msk, pd, rd);
      flg_q   <= (flg_q & ~(clr & ~match)) | (en_q & match);
      if (p_we && p_idx == PV_EN)  en_q  <= pd;
      if (p_we && p_idx == PV_OWN) own_q <= pd;
      sync1_q <= pin_in;
      sync_q  <= sync1_q;
      if (!init_done) init_cnt <= init_cnt + 2'd1;
      if (init_cnt == 2'd2) mir_q <= sync_q;
    end
  end

  logic [DATA_W-1:0] view [NWORDS];

  always_comb begin
    view[RV_OUT] = DATA_W'(out_q & own_q);
    view[RV_DIR] = DATA_W'(dir_q & own_q);
    view[RV_IN]  = DATA_W'(sync_q & own_q);
    view[RV_LVL] = DATA_W'(lvl_q & own_q);
    view[RV_FLG] = DATA_W'(flg_q & own_q);
    view[RV_MSK] = DATA_W'(msk_q & own_q);
    view[RV_MIR] = DATA_W'(mir_q & own_q);
    view[PV_EN]  = DATA_W'(en_q);
    view[PV_OUT] = DATA_W'(out_q);
    view[PV_DIR] = DATA_W'(dir_q);
    view[PV_IN]  = DATA_W'(sync_q);
    view[PV_LVL] = DATA_W'(lvl_q);
    view[PV_FLG] = DATA_W'(flg_q);
    view[PV_MSK] = DATA_W'(msk_q);
    view[PV_MIR] = DATA_W'(mir_q);
    view[PV_OWN] = DATA_W'(own_q);
  end

  assign p_rdata  = p_sel ? view[p_idx] : '0;
  assign r_rdata  = (r_sel && r_idx <= RV_MIR) ? view[r_idx] : '0;

  assign pin_oe   = dir_q & en_q;
  assign pin_out  = out_q & pin_oe;
  assign irq_priv = |(msk_q & flg_q & ~own_q);
  assign irq_rest = |(msk_q & flg_q & own_q);
endmodule

// File: rtl/gpio_dual_view_chk.sv
`timescale 1ns/1ps
module gpio_dual_view_chk #(
  parameter int N = 32,
  parameter int DW = 32,
  parameter int AW = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic [N-1:0]  pin_oe,
  input logic [N-1:0]  pin_out,
  input logic [N-1:0]  en_q,
  input logic [N-1:0]  own_q,
  input logic [N-1:0]  out_q,
  input logic [N-1:0]  flg_q,
  input logic [N-1:0]  lvl_q,
  input logic [N-1:0]  sync_q,
  input logic [N-1:0]  mir_q,
  input logic          init_done,
  input logic          p_sel,
  input logic          p_wr,
  input logic [AW-1:0] p_addr,
  input logic          r_sel,
  input logic          r_wr,
  input logic [AW-1:0] r_addr,
  input logic [DW-1:0] r_rdata
);
  wire [N-1:0] hot = en_q & ~(sync_q ^ lvl_q);

  a_r3_no_drive_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_oe & ~en_q) == '0);

  a_r2_quiet_when_input: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_out & ~pin_oe) == '0);

  a_r6_flag_held_on_match: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flg_q & $past(hot)) == $past(hot)));

  a_r7_rest_read_masked: assert property (@(posedge clk) disable iff (!rst_n)
    (r_sel && !r_wr) |-> ((r_rdata[N-1:0] & ~own_q) == '0));

  a_r8_owned_out_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (p_sel && p_wr && p_addr[5:2] == 4'd8 && !(r_sel && r_wr))
      |=> ((out_q & $past(own_q)) == $past(out_q & own_q)));

  a_r11_mirror_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    init_done |=> $stable(mir_q));
endmodule

bind gpio_dual_view gpio_dual_view_chk #(.N(NPINS), .DW(DATA_W), .AW(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .pin_oe(pin_oe), .pin_out(pin_out), .en_q(en_q),
  .own_q(own_q), .out_q(out_q), .flg_q(flg_q), .lvl_q(lvl_q), .sync_q(sync_q),
  .mir_q(mir_q), .init_done(init_done), .p_sel(p_sel), .p_wr(p_wr), .p_addr(p_addr),
  .r_sel(r_sel), .r_wr(r_wr), .r_addr(r_addr), .r_rdata(r_rdata)
);

// File: tb/tb_gpio_dual_view.sv
`timescale 1ns/1ps
module tb_gpio_dual_view;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic p_sel = 0, p_wr = 0, r_sel = 0, r_wr = 0;
  logic [5:0] p_addr = '0, r_addr = '0;
  logic [31:0] p_wdata = '0, r_wdata = '0, pin_in = '0;
  logic [31:0] p_rdata, r_rdata, pin_out, pin_oe;
  logic irq_priv, irq_rest;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_dual_view dut (
    .clk(clk), .rst_n(rst_n),
    .p_sel(p_sel), .p_wr(p_wr), .p_addr(p_addr), .p_wdata(p_wdata), .p_rdata(p_rdata),
    .r_sel(r_sel), .r_wr(r_wr), .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata),
    .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe),
    .irq_priv(irq_priv), .irq_rest(irq_rest)
  );

  logic [31:0] m_out, m_dir, m_lvl, m_msk, m_flg, m_en, m_own, m_mir, m_s1, m_s2;
  logic [31:0] n_out, n_dir, n_lvl, n_msk, n_en, n_own, n_clr;
  int m_age;

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic m_apply(input logic [5:0] a, input logic [31:0] d, input bit is_r);
    int idx;
    logic [31:0] g;
    idx = int'(a[5:2]);
    if (idx <= 6) g = m_own;
    else if (is_r) return;
    else g = ~m_own;
    case (idx)
      0, 8:   n_out = (n_out & ~g) | (d & g);
      1, 9:   n_dir = (n_dir & ~g) | (d & g);
      3, 11:  n_lvl = (n_lvl & ~g) | (d & g);
      4, 12:  n_clr = n_clr | (d & g);
      5, 13:  n_msk = (n_msk & ~g) | (d & g);
      7:      n_en = d;
      15:     n_own = d;
      default: ;
    endcase
  endtask

  function automatic logic [31:0] m_read(input logic sel, input logic [5:0] a, input bit is_r);
    int idx;
    idx = int'(a[5:2]);
    if (!sel || (is_r && idx > 6)) return '0;
    case (idx)
      0: return m_out & m_own;
      1: return m_dir & m_own;
      2: return m_s2 & m_own;
      3: return m_lvl & m_own;
      4: return m_flg & m_own;
      5: return m_msk & m_own;
      6: return m_mir & m_own;
      7: return m_en;
      8: return m_out;
      9: return m_dir;
      10: return m_s2;
      11: return m_lvl;
      12: return m_flg;
      13: return m_msk;
      14: return m_mir;
      default: return m_own;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_out = 0; m_dir = 0; m_msk = 0; m_flg = 0; m_own = 0; m_mir = 0;
      m_lvl = '1; m_en = 32'h00FF_FFFF; m_s1 = 0; m_s2 = 0; m_age = 0;
    end else begin
      n_out = m_out; n_dir = m_dir; n_lvl = m_lvl; n_msk = m_msk;
      n_en = m_en; n_own = m_own; n_clr = 0;
      if (r_sel && r_wr) m_apply(r_addr, r_wdata, 1'b1);
      if (p_sel && p_wr) m_apply(p_addr, p_wdata, 1'b0);
      for (int i = 0; i < 32; i++) begin
        if (n_clr[i] && m_s2[i] != m_lvl[i]) m_flg[i] = 1'b0;
        if (m_en[i] && m_s2[i] == m_lvl[i]) m_flg[i] = 1'b1;
      end
      m_age++;
      if (m_age == 3) m_mir = m_s2;
      m_s2 = m_s1;
      m_s1 = pin_in;
      m_out = n_out; m_dir = n_dir; m_lvl = n_lvl; m_msk = n_msk;
      m_en = n_en; m_own = n_own;
    end
  end

  always @(negedge clk) begin
    check(pin_oe, m_dir & m_en, "R2 pin_oe");
    check(pin_out, m_out & m_dir & m_en, "R2 pin_out");
    check({31'd0, irq_priv}, {31'd0, |(m_msk & m_flg & ~m_own)}, "R9 irq_priv");
    check({31'd0, irq_rest}, {31'd0, |(m_msk & m_flg & m_own)}, "R9 irq_rest");
    check(p_rdata, m_read(p_sel, p_addr, 1'b0), "R8 p_rdata");
    check(r_rdata, m_read(r_sel, r_addr, 1'b1), "R7 r_rdata");
  end

  task automatic idle();
    p_sel = 0; p_wr = 0; r_sel = 0; r_wr = 0;
  endtask
  task automatic tick();
    @(posedge clk); #5; idle();
  endtask
  task automatic setpin(input logic [31:0] v);
    @(posedge clk); #5; idle(); pin_in = v;
  endtask
  task automatic pwrite(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #5; idle(); p_sel = 1; p_wr = 1; p_addr = a; p_wdata = d;
  endtask
  task automatic rwrite(input logic [5:0] a, input logic [31:0] d);
    @(posedge clk); #5; idle(); r_sel = 1; r_wr = 1; r_addr = a; r_wdata = d;
  endtask
  task automatic both(input logic [5:0] a, input logic [31:0] dp, input logic [31:0] dr);
    @(posedge clk); #5;
    p_sel = 1; p_wr = 1; p_addr = a; p_wdata = dp;
    r_sel = 1; r_wr = 1; r_addr = a; r_wdata = dr;
  endtask
  task automatic pread(input logic [5:0] a, input logic [31:0] exp, input string req);
    @(posedge clk); #5; idle(); p_sel = 1; p_addr = a;
    @(negedge clk); #1; check(p_rdata, exp, req);
  endtask
  task automatic rread(input logic [5:0] a, input logic [31:0] exp, input string req);
    @(posedge clk); #5; idle(); r_sel = 1; r_addr = a;
    @(negedge clk); #1; check(r_rdata, exp, req);
  endtask

  initial begin
    pin_in = 32'h0000_00A5;
    repeat (3) @(posedge clk);
    #5 rst_n = 1'b1;
    repeat (4) tick();
    pread(6'h1C, 32'h00FF_FFFF, "R12 enable reset");
    pread(6'h2C, 32'hFFFF_FFFF, "R12 level reset");
    pread(6'h20, 32'h0, "R12 out reset");
    pread(6'h3C, 32'h0, "R12 owner reset");
    pread(6'h38, 32'h0000_00A5, "R11 mirror capture");
    pread(6'h30, 32'h0000_00A5, "R5 high-level flags");
    pwrite(6'h38, 32'h0);
    pread(6'h38, 32'h0000_00A5, "R14 mirror read-only");
    pwrite(6'h28, 32'h0);
    pread(6'h28, 32'h0000_00A5, "R14 input read-only");
    pwrite(6'h24, 32'h0F);
    pwrite(6'h20, 32'h05);
    tick(); @(negedge clk); #1;
    check(pin_oe, 32'h0F, "R2 oe");
    check(pin_out, 32'h05, "R2 out");
    pwrite(6'h20, 32'hF5);
    tick(); @(negedge clk); #1;
    check(pin_out, 32'h05, "R2 input pins quiet");
    pwrite(6'h1C, 32'hFFFF_FBF0);
    tick(); @(negedge clk); #1;
    check(pin_oe, 32'h0, "R3 disabled no drive");
    setpin(32'h0000_04A5);
    repeat (4) tick();
    pread(6'h30, 32'h0000_00A5, "R3 disabled no flag");
    pwrite(6'h1C, 32'h00FF_FFFF);
    tick(); tick();
    pread(6'h30, 32'h0000_04A5, "R3 enabled flag sets");
    setpin(32'h0000_0100);
    pread(6'h28, 32'h0000_04A5, "R4 one edge old");
    pread(6'h28, 32'h0000_0100, "R4 two edges new");
    tick();
    pread(6'h30, 32'h0000_05A5, "R5 flag sets");
    pwrite(6'h30, 32'h0000_05A5);
    pread(6'h30, 32'h0000_0100, "R6 clear blocked on match");
    setpin(32'h0);
    tick(); tick();
    pwrite(6'h30, 32'h0000_0100);
    pread(6'h30, 32'h0, "R6 clear after idle");
    pwrite(6'h2C, 32'hFFFF_FDFF);
    tick();
    pread(6'h30, 32'h0000_0200, "R5 low-level flag");
    pwrite(6'h34, 32'h0000_0200);
    tick(); @(negedge clk); #1;
    check({31'd0, irq_priv}, 32'd1, "R9 priv irq");
    check({31'd0, irq_rest}, 32'd0, "R9 rest irq idle");
    pwrite(6'h3C, 32'h0000_0200);
    tick(); @(negedge clk); #1;
    check({31'd0, irq_priv}, 32'd0, "R9 priv irq moved");
    check({31'd0, irq_rest}, 32'd1, "R10 rest irq shared mask");
    rread(6'h14, 32'h0000_0200, "R10 mask visible");
    rread(6'h04, 32'h0, "R7 unowned reads zero");
    pwrite(6'h3C, 32'h0000_020F);
    rread(6'h04, 32'h0000_000F, "R10 dir visible");
    rwrite(6'h00, 32'hFFFF_FFFF);
    pread(6'h20, 32'h0000_02FF, "R7 owned bits only");
    pwrite(6'h20, 32'h0);
    pread(6'h20, 32'h0000_020F, "R8 owned out kept");
    pwrite(6'h24, 32'h0);
    pread(6'h24, 32'h0000_000F, "R8 owned dir kept");
    both(6'h00, 32'h0, 32'hFFFF_FFFF);
    pread(6'h20, 32'h0, "R13 privileged wins");
    rread(6'h1C, 32'h0, "R1 rest high window");
    rwrite(6'h3C, 32'h0);
    pread(6'h3C, 32'h0000_020F, "R1 rest owner write ignored");
    pread(6'h14, 32'h0000_0200, "R1 priv reads rest window");
    rwrite(6'h10, 32'h0000_0200);
    tick(); @(negedge clk); #1;
    check({31'd0, irq_rest}, 32'd1, "R6 rest clear blocked");
    rwrite(6'h0C, 32'hFFFF_FFFF);
    rwrite(6'h10, 32'h0000_0200);
    tick(); @(negedge clk); #1;
    check({31'd0, irq_rest}, 32'd0, "R9 rest irq cleared");
    pread(6'h30, 32'h0, "R6 rest clear done");
    tick();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: run did not complete (R1)");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule